// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space requester and the outbound fabric of a PCI Express root port. Each request names a bus, a device, a function and a register offset, and is either a read or a write. The block screens the request against the device numbers that can exist below the root port. It then works out where the access must go: either the root port's own register window, or the outbound configuration window with a transaction type and a packed target word. It issues the access and returns the completion to the requester.

Requests to devices that cannot exist never reach the fabric. A read of such a device completes with all ones, and a write to one completes with an error flag. A read that the fabric completes with an error also returns all ones, so a probing requester always sees a defined value. Both sides use valid/ready handshakes, and only one request is in flight at a time.

Top module: `cfgx_xlat`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1 and `ob_valid` and `rsp_valid` are 0.
- R2: The outbound kind is 4 (type-0 configuration) for bus 0 and bus 1, and 5 (type-1 configuration) for bus 2 and above. Encodings 0 (memory) and 2 (I/O) are reserved for other traffic and are never produced.
- R3: A bus-0 request is issued with `ob_local` = 1, `ob_target` = 0 and `ob_addr` = `LOCAL_BASE` + aligned offset.
- R4: A request on any other bus is issued with `ob_local` = 0 and `ob_addr` = `APER_BASE` + `APER_SIZE` − `WIN_SIZE` + aligned offset. `ob_target` carries the bus in bits 31:24, the device in bits 23:19 and the function in bits 18:16, with the other bits 0.
- R5: The aligned offset is `req_off` with its two low bits cleared, so `ob_addr[1:0]` is always 0.
- R6: A request on bus 0 with a device above `BUS0_MAX_DEV` (default 1), or on bus 1 with a device above `BUS1_MAX_DEV` (default 0), is never issued outbound. Its response is valid in the cycle after acceptance.
- R7: The response to such a rejected read is `rsp_rdata` = 0xFFFFFFFF with `rsp_err` = 0. The response to a rejected write has `rsp_err` = 1.
- R8: When the fabric completes a read with `obr_err` = 1, the response is `rsp_rdata` = 0xFFFFFFFF with `rsp_err` = 1. When it completes a write with an error, `rsp_err` = 1.
- R9: A read that the fabric completes without error returns `obr_data` unchanged, with `rsp_err` = 0.
- R10: `req_ready` is 1 only when nothing is outstanding, and never together with `ob_valid` or `rsp_valid`. The outbound fields hold steady while `ob_valid` is 1 and `ob_ready` is 0. The response fields hold steady while `rsp_valid` is 1 and `rsp_ready` is 0.
- R11: A write is issued with `ob_write` = 1 and `ob_wdata` equal to the accepted `req_wdata`. Every write response carries `rsp_rdata` = 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_bus | input | BUS_W | Bus number |
| req_dev | input | DEV_W | Device number |
| req_fn | input | FN_W | Function number |
| req_off | input | OFS_W | Register byte offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_rdata | output | 32 | Read data (all ones for writes and failed reads) |
| rsp_err | output | 1 | Completion error |
| ob_valid | output | 1 | Outbound access valid |
| ob_ready | input | 1 | Outbound access accepted |
| ob_addr | output | 32 | Local or window address |
| ob_kind | output | 3 | Transaction type encoding |
| ob_target | output | 32 | Packed bus/device/function target word |
| ob_local | output | 1 | Access targets the local register window |
| ob_write | output | 1 | Outbound write |
| ob_wdata | output | 32 | Outbound write data |
| obr_valid | input | 1 | Fabric completion valid |
| obr_data | input | 32 | Fabric completion data |
| obr_err | input | 1 | Fabric completion error |

## Verification
The bench uses the default parameters: an 8-bit bus field, a 5-bit device field, a 3-bit function field, a 12-bit offset, and device limits of 1 on bus 0 and 0 on bus 1. These sizes let the stimulus reach bus 255 with device 31 and function 7, the top dword at offset 0xFFF with unaligned low bits, and both rejection limits from just inside and just outside. The fabric model completes every access to bus 0xEE with an error, which covers both error paths. Stalls on all three handshakes come from fixed patterns of `ob_ready`, `rsp_ready` and completion latency, so the hold rules are exercised in every phase.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int unsigned CFGX_AW = 32;
  localparam int unsigned CFGX_DW = 32;

  // transaction type encodings carried on the outbound side
  typedef enum logic [2:0] {
    KIND_MEM  = 3'd0,
    KIND_IO   = 3'd2,
    KIND_CFG0 = 3'd4,
    KIND_CFG1 = 3'd5
  } xact_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xlat_state_e;

  typedef struct packed {
    logic [CFGX_AW-1:0] addr;
    logic [CFGX_DW-1:0] target;
    xact_kind_e         kind;
    logic               is_local;
    logic               bad;
  } xlat_t;

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode #(
  parameter int unsigned BUS_W        = 8,
  parameter int unsigned DEV_W        = 5,
  parameter int unsigned FN_W         = 3,
  parameter int unsigned OFS_W        = 12,
  parameter int unsigned BUS0_MAX_DEV = 1,
  parameter int unsigned BUS1_MAX_DEV = 0,
  parameter logic [31:0] LOCAL_BASE   = 32'h01FF_C000,
  parameter logic [31:0] WIN_BASE     = 32'h01F0_0000
) (
  input  logic [BUS_W-1:0]    bus,
  input  logic [DEV_W-1:0]    dev,
  input  logic [FN_W-1:0]     fn,
  input  logic [OFS_W-1:0]    off,
  output cfgx_pkg::xlat_t     xl
);
  import cfgx_pkg::*;

  // target word layout: bus at the top, then device, then function
  localparam int unsigned TGT_BUS_LSB = CFGX_DW - BUS_W;
  localparam int unsigned TGT_DEV_LSB = TGT_BUS_LSB - DEV_W;
  localparam int unsigned TGT_FN_LSB  = TGT_DEV_LSB - FN_W;
  localparam logic [DEV_W-1:0] LIM0 = DEV_W'(BUS0_MAX_DEV);
  localparam logic [DEV_W-1:0] LIM1 = DEV_W'(BUS1_MAX_DEV);
  localparam logic [BUS_W-1:0] BUS_ONE = BUS_W'(1);

  logic [OFS_W-1:0]   off_al;
  logic               on_root;
  logic               on_first;

  always_comb begin
    off_al   = {off[OFS_W-1:2], 2'b00};
    on_root  = (bus == '0);
    on_first = (bus == BUS_ONE);

    xl.bad      = (on_root && (dev > LIM0)) || (on_first && (dev > LIM1));
    xl.is_local = on_root;
    xl.kind     = (on_root || on_first) ? KIND_CFG0 : KIND_CFG1;

    xl.target = '0;
    if (!on_root) begin
      xl.target[TGT_BUS_LSB +: BUS_W] = bus;
      xl.target[TGT_DEV_LSB +: DEV_W] = dev;
      xl.target[TGT_FN_LSB  +: FN_W]  = fn;
    end

    xl.addr = (on_root ? LOCAL_BASE : WIN_BASE) + CFGX_AW'(off_al);
  end

endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [cfgx_pkg::CFGX_DW-1:0] req_wdata,
  input  cfgx_pkg::xlat_t           xl,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [cfgx_pkg::CFGX_DW-1:0] rsp_rdata,
  output logic                      rsp_err,
  output logic                      ob_valid,
  input  logic                      ob_ready,
  output logic [cfgx_pkg::CFGX_AW-1:0] ob_addr,
  output logic [2:0]                ob_kind,
  output logic [cfgx_pkg::CFGX_DW-1:0] ob_target,
  output logic                      ob_local,
  output logic                      ob_write,
  output logic [cfgx_pkg::CFGX_DW-1:0] ob_wdata,
  input  logic                      obr_valid,
  input  logic [cfgx_pkg::CFGX_DW-1:0] obr_data,
  input  logic                      obr_err
);
  import cfgx_pkg::*;

  xlat_state_e          state_q, state_d;
  logic                 ld_req, ld_rsp;
  logic [CFGX_AW-1:0]   addr_q;
  logic [CFGX_DW-1:0]   tgt_q, wdata_q, rdata_q, rdata_d;
  xact_kind_e           kind_q;
  logic                 local_q, wr_q, err_q, err_d;

  // next-state and response data
  always_comb begin
    state_d = state_q;
    ld_req  = 1'b0;
    ld_rsp  = 1'b0;
    rdata_d = rdata_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        ld_req  = 1'b1;
        ld_rsp  = 1'b1;
        rdata_d = '1;
        err_d   = xl.bad & req_write;
        state_d = xl.bad ? ST_RESP : ST_ISSUE;
      end
      ST_ISSUE: if (ob_ready) state_d = ST_WAIT;
      ST_WAIT: if (obr_valid) begin
        ld_rsp  = 1'b1;
        rdata_d = (wr_q || obr_err) ? '1 : obr_data;
        err_d   = obr_err;
        state_d = ST_RESP;
      end
      ST_RESP: if (rsp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // request capture, enabled on acceptance only
  always_ff @(posedge clk) begin
    if (ld_req) begin
      addr_q  <= xl.addr;
      tgt_q   <= xl.target;
      kind_q  <= xl.kind;
      local_q <= xl.is_local;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  // response capture
  always_ff @(posedge clk) begin
    if (ld_rsp) begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ob_valid  = (state_q == ST_ISSUE);
  assign rsp_valid = (state_q == ST_RESP);
  assign ob_addr   = addr_q;
  assign ob_kind   = kind_q;
  assign ob_target = tgt_q;
  assign ob_local  = local_q;
  assign ob_write  = wr_q;
  assign ob_wdata  = wdata_q;
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

endmodule

// File: rtl/cfgx_xlat.sv
module cfgx_xlat #(
  parameter int unsigned BUS_W        = 8,
  parameter int unsigned DEV_W        = 5,
  parameter int unsigned FN_W         = 3,
  parameter int unsigned OFS_W        = 12,
  parameter int unsigned BUS0_MAX_DEV = 1,
  parameter int unsigned BUS1_MAX_DEV = 0,
  parameter logic [31:0] LOCAL_BASE   = 32'h01FF_C000,
  parameter logic [31:0] APER_BASE    = 32'h0100_0000,
  parameter logic [31:0] APER_SIZE    = 32'h0100_0000,
  parameter logic [31:0] WIN_SIZE     = 32'h0010_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [FN_W-1:0]    req_fn,
  input  logic [OFS_W-1:0]   req_off,
  input  logic               req_write,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic               ob_valid,
  input  logic               ob_ready,
  output logic [31:0]        ob_addr,
  output logic [2:0]         ob_kind,
  output logic [31:0]        ob_target,
  output logic               ob_local,
  output logic               ob_write,
  output logic [31:0]        ob_wdata,
  input  logic               obr_valid,
  input  logic [31:0]        obr_data,
  input  logic               obr_err
);
  // configuration window sits at the top of the aperture
  localparam logic [31:0] WIN_BASE = APER_BASE + APER_SIZE - WIN_SIZE;

  cfgx_pkg::xlat_t xl;

  cfgx_decode #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFS_W(OFS_W),
    .BUS0_MAX_DEV(BUS0_MAX_DEV), .BUS1_MAX_DEV(BUS1_MAX_DEV),
    .LOCAL_BASE(LOCAL_BASE), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .bus(req_bus), .dev(req_dev), .fn(req_fn), .off(req_off), .xl(xl)
  );

  cfgx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wdata(req_wdata), .xl(xl),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_addr(ob_addr),
    .ob_kind(ob_kind), .ob_target(ob_target), .ob_local(ob_local),
    .ob_write(ob_write), .ob_wdata(ob_wdata),
    .obr_valid(obr_valid), .obr_data(obr_data), .obr_err(obr_err)
  );

endmodule

// File: rtl/cfgx_xlat_chk.sv
module cfgx_xlat_chk #(
  parameter int unsigned BUS_W        = 8,
  parameter int unsigned DEV_W        = 5,
  parameter int unsigned BUS0_MAX_DEV = 1,
  parameter int unsigned BUS1_MAX_DEV = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [BUS_W-1:0] req_bus,
  input logic [DEV_W-1:0] req_dev,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic             rsp_err,
  input logic             ob_valid,
  input logic             ob_ready,
  input logic [31:0]      ob_addr,
  input logic [2:0]       ob_kind,
  input logic [31:0]      ob_target,
  input logic             ob_local,
  input logic             ob_write,
  input logic             obr_valid,
  input logic             obr_err
);
  localparam int unsigned TB_LSB = 32 - BUS_W;

  logic rej;
  logic waiting_q, pend_wr_q;

  assign rej = ((req_bus == '0) && (int'(req_dev) > BUS0_MAX_DEV)) ||
               ((req_bus == BUS_W'(1)) && (int'(req_dev) > BUS1_MAX_DEV));

  // track an outstanding fabric access from the port side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_q <= 1'b0;
      pend_wr_q <= 1'b0;
    end else if (ob_valid && ob_ready) begin
      waiting_q <= 1'b1;
      pend_wr_q <= ob_write;
    end else if (obr_valid) begin
      waiting_q <= 1'b0;
    end
  end

  assert_idle_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ob_valid && !rsp_valid));

  assert_ob_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && !ob_ready) |=> (ob_valid && $stable(ob_addr) &&
                                 $stable(ob_target) && $stable(ob_kind)));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && ob_local) |-> (ob_kind == 3'd4 && ob_target == 32'd0));

  assert_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && !ob_local) |-> (ob_target[TB_LSB +: BUS_W] != '0 &&
      ob_kind == ((ob_target[TB_LSB +: BUS_W] == BUS_W'(1)) ? 3'd4 : 3'd5)));

  assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid |-> (ob_addr[1:0] == 2'b00));

  assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rej) |=> (rsp_valid && !ob_valid));

  assert_badwr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rej && req_write) |=> rsp_err);

  assert_errread_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_q && !pend_wr_q && obr_valid && obr_err) |=>
      (rsp_valid && rsp_err && rsp_rdata == 32'hFFFF_FFFF));

endmodule

bind cfgx_xlat cfgx_xlat_chk #(
  .BUS_W(BUS_W), .DEV_W(DEV_W),
  .BUS0_MAX_DEV(BUS0_MAX_DEV), .BUS1_MAX_DEV(BUS1_MAX_DEV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bus(req_bus), .req_dev(req_dev), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .ob_valid(ob_valid), .ob_ready(ob_ready),
  .ob_addr(ob_addr), .ob_kind(ob_kind), .ob_target(ob_target),
  .ob_local(ob_local), .ob_write(ob_write),
  .obr_valid(obr_valid), .obr_err(obr_err)
);

// File: tb/tb_cfgx_xlat.sv
module tb_cfgx_xlat;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LBASE = 32'h01FF_C000;
  localparam logic [31:0] WBASE = 32'h01F0_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [7:0] req_bus;
  logic [4:0] req_dev;
  logic [2:0] req_fn;
  logic [11:0] req_off;
  logic [31:0] req_wdata;
  logic rsp_valid, rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic ob_valid, ob_ready, ob_local, ob_write;
  logic [31:0] ob_addr, ob_target, ob_wdata;
  logic [2:0] ob_kind;
  logic obr_valid, obr_err;
  logic [31:0] obr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgx_xlat dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_bus(req_bus),
    .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .ob_valid(ob_valid), .ob_ready(ob_ready),
    .ob_addr(ob_addr), .ob_kind(ob_kind), .ob_target(ob_target),
    .ob_local(ob_local), .ob_write(ob_write), .ob_wdata(ob_wdata),
    .obr_valid(obr_valid), .obr_data(obr_data), .obr_err(obr_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // reference model state (phase 0 idle, 1 issuing, 2 waiting, 3 responding)
  int ph = 0;
  int cnt = 0;
  bit m_bad = 0, e_loc = 0, e_wr = 0, e_err = 0;
  logic [31:0] e_addr, e_tgt, e_wd, e_rd, pend_data;
  logic [2:0] e_kind;
  bit pend_err;
  logic [31:0] mem [logic [63:0]];

  // snapshots taken at the falling edge
  bit s_rst, s_rv, s_wr, s_ordy, s_obrv, s_obrerr, s_rrdy;
  logic [7:0] s_bus;
  logic [4:0] s_dev;
  logic [2:0] s_fn;
  logic [11:0] s_off;
  logic [31:0] s_wd, s_obrdata;

  always begin
    @(negedge clk);
    cyc++;
    chk(rst_n ? "R10 req_ready" : "R1 req_ready", 32'(req_ready), 32'(ph == 0));
    chk(m_bad ? "R6 ob_valid" : (rst_n ? "R10 ob_valid" : "R1 ob_valid"),
        32'(ob_valid), 32'(ph == 1));
    chk(rst_n ? "R10 rsp_valid" : "R1 rsp_valid", 32'(rsp_valid), 32'(ph == 3));
    if (ph == 1) begin
      chk("R2 ob_kind", 32'(ob_kind), 32'(e_kind));
      chk(e_loc ? "R3 ob_addr" : "R4 ob_addr", ob_addr, e_addr);
      chk(e_loc ? "R3 ob_target" : "R4 ob_target", ob_target, e_tgt);
      chk(e_loc ? "R3 ob_local" : "R4 ob_local", 32'(ob_local), 32'(e_loc));
      chk("R5 ob_addr alignment", 32'(ob_addr[1:0]), 32'd0);
      chk("R11 ob_write", 32'(ob_write), 32'(e_wr));
      if (e_wr) chk("R11 ob_wdata", ob_wdata, e_wd);
    end
    if (ph == 3) begin
      chk(m_bad ? "R7 rsp_rdata" : (e_err ? "R8 rsp_rdata" : (e_wr ? "R11 rsp_rdata" : "R9 rsp_rdata")),
          rsp_rdata, e_rd);
      chk(m_bad ? "R7 rsp_err" : (e_err ? "R8 rsp_err" : "R9 rsp_err"),
          32'(rsp_err), 32'(e_err));
    end
    s_rst = rst_n; s_rv = req_valid; s_wr = req_write; s_bus = req_bus;
    s_dev = req_dev; s_fn = req_fn; s_off = req_off; s_wd = req_wdata;
    s_ordy = ob_ready; s_obrv = obr_valid; s_obrerr = obr_err;
    s_obrdata = obr_data; s_rrdy = rsp_ready;

    @(posedge clk);
    #1;
    if (!s_rst) begin
      ph = 0; cnt = 0; m_bad = 0;
      obr_valid = 0; obr_err = 0; obr_data = '0;
    end else begin
      // fabric completion driver
      obr_valid = 0;
      if (cnt == 1) begin
        obr_valid = 1; obr_data = pend_data; obr_err = pend_err; cnt = 0;
      end else if (cnt > 1) cnt--;
      case (ph)
        0: if (s_rv) begin
          e_loc  = (s_bus == 0);
          e_kind = (s_bus < 2) ? 3'd4 : 3'd5;
          e_tgt  = e_loc ? 32'd0 : {s_bus, s_dev, s_fn, 16'h0000};
          e_addr = (e_loc ? LBASE : WBASE) + {20'h0, s_off[11:2], 2'b00};
          e_wr   = s_wr;
          e_wd   = s_wd;
          m_bad  = (s_bus == 0 && s_dev > 1) || (s_bus == 1 && s_dev > 0);
          if (m_bad) begin
            ph = 3; e_rd = 32'hFFFF_FFFF; e_err = s_wr;
          end else ph = 1;
        end
        1: if (s_ordy) begin
          logic [63:0] key;
          key = {e_tgt, e_addr};
          pend_err = !e_loc && (e_tgt[31:24] == 8'hEE);
          if (e_wr && !pend_err) mem[key] = e_wd;
          pend_data = mem.exists(key) ? mem[key] : (e_addr ^ e_tgt ^ 32'h5A5A_0000);
          cnt = 1 + (cyc % 3);
          ph = 2;
        end
        2: if (s_obrv) begin
          e_err = s_obrerr;
          e_rd  = (e_wr || s_obrerr) ? 32'hFFFF_FFFF : s_obrdata;
          ph = 3;
        end
        default: if (s_rrdy) ph = 0;
      endcase
    end
    ob_ready  = (cyc % 4) != 2;
    rsp_ready = (cyc % 3) != 1;
  end

  task automatic send(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                      input logic [11:0] o, input logic w, input logic [31:0] wd);
    @(posedge clk);
    #1;
    req_bus = b; req_dev = d; req_fn = f; req_off = o;
    req_write = w; req_wdata = wd; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    do @(negedge clk); while (!(rsp_valid && rsp_ready));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_bus = 0; req_dev = 0; req_fn = 0;
    req_off = 0; req_wdata = 0; ob_ready = 0; rsp_ready = 0;
    obr_valid = 0; obr_err = 0; obr_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R3 R5: local window, unaligned offset
    send(8'h00, 5'd0, 3'd0, 12'h07E, 1'b0, 32'h0);
    send(8'h00, 5'd1, 3'd2, 12'h010, 1'b1, 32'hCAFE_0001);
    send(8'h00, 5'd1, 3'd2, 12'h013, 1'b0, 32'h0);
    // R6 R7: rejected devices, read and write
    send(8'h00, 5'd2, 3'd0, 12'h000, 1'b0, 32'h0);
    send(8'h01, 5'd1, 3'd0, 12'h004, 1'b1, 32'h1234_5678);
    send(8'h01, 5'd31, 3'd7, 12'h004, 1'b0, 32'h0);
    // R4 R9 R11: bus 1 write then read back
    send(8'h01, 5'd0, 3'd3, 12'h0A2, 1'b1, 32'hDEAD_BEEF);
    send(8'h01, 5'd0, 3'd3, 12'h0A0, 1'b0, 32'h0);
    // R2: type-1 on higher buses, extremes of the fields
    send(8'h02, 5'd31, 3'd7, 12'hFFF, 1'b0, 32'h0);
    send(8'hFF, 5'd0, 3'd0, 12'h000, 1'b1, 32'h0BAD_F00D);
    send(8'hFF, 5'd0, 3'd0, 12'h001, 1'b0, 32'h0);
    // R8: fabric error on read and write
    send(8'hEE, 5'd3, 3'd1, 12'h040, 1'b0, 32'h0);
    send(8'hEE, 5'd3, 3'd1, 12'h040, 1'b1, 32'h5555_AAAA);
    for (int i = 0; i < 48; i++) begin
      send(8'((i * 37) % 5 == 0 ? 0 : (i * 37) % 7), 5'((i * 11) % 4),
           3'(i % 8), 12'((i * 173) % 4096), 1'(i % 3 == 0), 32'(i * 32'h0101_0101));
    end
    repeat (5) @(posedge clk);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule